// File: doc/BRIEF.md
# Interrupt Redirection Table Controller

This block routes device interrupt lines to processors. Each of its 24 input pins owns one 64-bit redirection entry. The entry sets the vector, the delivery mode, the destination and how it is read, the input polarity, the trigger type and a mask. Software writes and reads the entries through a flat register port: an index, a write strobe, 64-bit write data and combinational read data.

When an unmasked pin signals, the block builds an interrupt message and presents it on a valid/ready output. Edge-triggered pins hold a single pending event until that event is loaded for sending. Level-triggered pins request while they are active. Once a level message is accepted, the pin raises a remote-acceptance flag, and the flag blocks further messages until an end-of-interrupt carrying the same vector arrives. When several pins request at the same time, a rotating pointer picks the next one, and each handshake carries one message.

Top module: `irq_router`

## Requirements
- R1: After reset every entry reads 64'h0000_0000_0001_0000 (mask bit 16 set, all else zero) and msg_valid is 0.
- R2: Entry fields are writable: vector 7:0, delivery mode 10:8, destination mode 11, polarity 13, trigger 15, mask 16 and destination 63:56. Bits 55:17 read as zero. Bits 12 and 14 ignore writes.
- R3: On an unmasked edge pin (bit 15 = 0), an inactive-to-active change produces exactly one message carrying the entry's vector, delivery mode and destination mode. Holding the pin active produces no further messages.
- R4: With bit 13 = 1 the pin is active low, so a falling input is the triggering edge and a rising input is not.
- R5: An edge on a masked pin (bit 16 = 1) is discarded. Clearing the mask afterwards produces no message.
- R6: An unmasked level pin (bit 15 = 1) that is active produces one message. Its acceptance sets bit 14, and no further message is sent while bit 14 is set, even if the pin stays active.
- R7: An end-of-interrupt with a matching vector clears bit 14 of level entries, and a pin that is still active then sends a new message. A non-matching vector changes nothing.
- R8: In physical mode (bit 11 = 0) msg_dest is {4'b0, entry bits 59:56}. In logical mode (bit 11 = 1) msg_dest is entry bits 63:56.
- R9: While msg_valid is 1 and msg_ready is 0, msg_valid stays 1 and all message fields stay stable.
- R10: Pins requesting together are served in rotating order. The search starts at the pin after the last one granted and wraps past pin 23 back to pin 0.
- R11: Setting the mask of a pin whose message is already presented does not withdraw that message.
- R12: Bit 12 reads 1 while the pin has a request waiting or its message is presented, and reads 0 once the message is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin | input | 24 | Interrupt input pins |
| cfg_we | input | 1 | Entry write strobe |
| cfg_addr | input | 5 | Entry index for read and write |
| cfg_wdata | input | 64 | Entry write data |
| cfg_rdata | output | 64 | Entry read data for cfg_addr |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | End-of-interrupt vector |
| msg_valid | output | 1 | Message presented |
| msg_ready | input | 1 | Message accepted by the receiver |
| msg_vector | output | 8 | Message vector |
| msg_dlv | output | 3 | Message delivery mode |
| msg_logical | output | 1 | Message destination mode, 1 = logical |
| msg_dest | output | 8 | Message destination |

## Verification
The hardest case to reach from the ports is several pins contending while the rotating pointer sits beyond the lower-numbered requester. That case is the only way to show wrap-around order rather than fixed priority. The bench holds msg_ready low, pulses three pins in one cycle, then releases the output. This leaves the pointer past pin 20. It then pulses pins 8 and 22 together under backpressure and expects pin 22 first. The remote-acceptance sequence is reached the same way: a level pin is held active across accept, a stray end-of-interrupt and a matching one, and the register port is read back at each stage.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int VEC_W     = 8;
  localparam int DLV_W     = 3;
  localparam int DEST_W    = 8;
  localparam int ENTRY_W   = 64;

  localparam int DLV_LSB   = 8;
  localparam int DMODE_BIT = 11;
  localparam int STAT_BIT  = 12;
  localparam int POL_BIT   = 13;
  localparam int RACC_BIT  = 14;
  localparam int TRIG_BIT  = 15;
  localparam int MASK_BIT  = 16;
  localparam int DEST_LSB  = 56;

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic              mask;
    logic              trig;     // 1 = level
    logic              pol;      // 1 = active low
    logic              logical;
    logic [DLV_W-1:0]  dlv;
    logic [VEC_W-1:0]  vec;
  } irq_cfg_t;

  function automatic irq_cfg_t unpack_entry(input logic [ENTRY_W-1:0] d);
    irq_cfg_t c;
    c.dest    = d[DEST_LSB +: DEST_W];
    c.mask    = d[MASK_BIT];
    c.trig    = d[TRIG_BIT];
    c.pol     = d[POL_BIT];
    c.logical = d[DMODE_BIT];
    c.dlv     = d[DLV_LSB +: DLV_W];
    c.vec     = d[VEC_W-1:0];
    return c;
  endfunction

  function automatic logic [ENTRY_W-1:0] pack_entry(input irq_cfg_t c,
                                                     input logic st,
                                                     input logic racc);
    logic [ENTRY_W-1:0] d;
    d                        = '0;
    d[DEST_LSB +: DEST_W]    = c.dest;
    d[MASK_BIT]              = c.mask;
    d[TRIG_BIT]              = c.trig;
    d[RACC_BIT]              = racc;
    d[POL_BIT]               = c.pol;
    d[STAT_BIT]              = st;
    d[DMODE_BIT]             = c.logical;
    d[DLV_LSB +: DLV_W]      = c.dlv;
    d[VEC_W-1:0]             = c.vec;
    return d;
  endfunction

endpackage

// File: rtl/irq_entry_bank.sv
module irq_entry_bank
  import irq_router_pkg::*;
#(
  parameter int N_PINS = 24,
  parameter int IDX_W  = $clog2(N_PINS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [ENTRY_W-1:0]        wr_data,
  output irq_cfg_t [N_PINS-1:0]     cfg_o
);

  irq_cfg_t [N_PINS-1:0] cfg_q;
  irq_cfg_t [N_PINS-1:0] cfg_d;
  irq_cfg_t              wr_cfg;

  assign wr_cfg = unpack_entry(wr_data);

  for (genvar i = 0; i < N_PINS; i++) begin : g_entry
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(i));

    always_comb begin
      cfg_d[i] = cfg_q[i];
      if (sel) cfg_d[i] = wr_cfg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[i]      <= '0;
        cfg_q[i].mask <= 1'b1;
      end else if (sel) begin
        cfg_q[i] <= cfg_d[i];
      end
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      sel |=> (cfg_q[i].vec == $past(wr_data[VEC_W-1:0])) &&
              (cfg_q[i].dest == $past(wr_data[DEST_LSB +: DEST_W]))); // R2
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/irq_pin_tracker.sv
module irq_pin_tracker
  import irq_router_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pin_i,
  input  irq_cfg_t cfg_i,
  input  logic     busy_i,     // this pin's message is presented
  input  logic     load_i,     // this pin is loaded into the output stage
  input  logic     accept_i,   // this pin's message completes its handshake
  input  logic     eoi_hit_i,  // end-of-interrupt with this entry's vector
  output logic     req_o,
  output logic     racc_o,
  output logic     status_o
);

  logic act;
  logic prev_q, prev_d;
  logic pend_q, pend_d;
  logic racc_q, racc_d;
  logic edge_det;

  assign act      = pin_i ^ cfg_i.pol;
  assign edge_det = act & ~prev_q;

  always_comb begin
    prev_d = act;

    pend_d = pend_q;
    if (cfg_i.mask || cfg_i.trig) pend_d = 1'b0;
    else if (edge_det)            pend_d = 1'b1;
    else if (load_i)              pend_d = 1'b0;

    racc_d = racc_q;
    if (!cfg_i.trig)     racc_d = 1'b0;
    else if (accept_i)   racc_d = 1'b1;
    else if (eoi_hit_i)  racc_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      racc_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      pend_q <= pend_d;
      racc_q <= racc_d;
    end
  end

  assign req_o    = ~busy_i & (cfg_i.trig ? (act & ~cfg_i.mask & ~racc_q) : pend_q);
  assign racc_o   = racc_q;
  assign status_o = req_o | busy_i;

  AST_MASK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_i.mask |=> !pend_q); // R5

  AST_ACCEPT_SETS_RACC: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && cfg_i.trig) |=> racc_q); // R6

  AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_hit_i && !accept_i && racc_q) |=> !racc_q); // R7

endmodule

// File: rtl/irq_rr_arbiter.sv
module irq_rr_arbiter #(
  parameter int N_PINS = 24,
  parameter int IDX_W  = $clog2(N_PINS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] req_i,
  input  logic              advance_i,
  output logic              gnt_any_o,
  output logic [IDX_W-1:0]  gnt_idx_o
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_PINS - 1);

  logic [IDX_W-1:0] ptr_q, ptr_d;

  always_comb begin
    gnt_any_o = 1'b0;
    gnt_idx_o = '0;
    for (int k = 0; k < N_PINS; k++) begin
      int cand;
      cand = int'(ptr_q) + k;
      if (cand >= N_PINS) cand = cand - N_PINS;
      if (!gnt_any_o && req_i[cand]) begin
        gnt_any_o = 1'b1;
        gnt_idx_o = IDX_W'(cand);
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (advance_i) ptr_d = (gnt_idx_o == LAST) ? '0 : gnt_idx_o + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ptr_q <= '0;
    else if (advance_i) ptr_q <= ptr_d;
  end

  AST_GNT_IS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_any_o |-> req_i[gnt_idx_o]); // R10

  AST_NO_REQ_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == '0) |-> !gnt_any_o); // R10

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int N_PINS = 24,
  parameter int IDX_W  = $clog2(N_PINS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] irq_pin,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_addr,
  input  logic [63:0]       cfg_wdata,
  output logic [63:0]       cfg_rdata,
  input  logic              eoi_valid,
  input  logic [7:0]        eoi_vector,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [7:0]        msg_vector,
  output logic [2:0]        msg_dlv,
  output logic              msg_logical,
  output logic [7:0]        msg_dest
);

  irq_cfg_t [N_PINS-1:0] cfg;
  logic [N_PINS-1:0]     req, racc, status, busy, accept, load_pin, eoi_hit;
  logic                  gnt_any, load;
  logic [IDX_W-1:0]      gnt_idx;
  irq_cfg_t              gcfg;

  logic                  out_valid_q, out_valid_d;
  logic [IDX_W-1:0]      out_pin_q, out_pin_d;
  logic [VEC_W-1:0]      out_vec_q, out_vec_d;
  logic [DLV_W-1:0]      out_dlv_q, out_dlv_d;
  logic                  out_log_q, out_log_d;
  logic [DEST_W-1:0]     out_dest_q, out_dest_d;

  irq_entry_bank #(.N_PINS(N_PINS), .IDX_W(IDX_W)) i_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_idx  (cfg_addr),
    .wr_data (cfg_wdata),
    .cfg_o   (cfg)
  );

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    assign busy[i]     = out_valid_q && (out_pin_q == IDX_W'(i));
    assign accept[i]   = busy[i] && msg_ready;
    assign load_pin[i] = load && (gnt_idx == IDX_W'(i));
    assign eoi_hit[i]  = eoi_valid && (eoi_vector == cfg[i].vec) && cfg[i].trig;

    irq_pin_tracker i_trk (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_i     (irq_pin[i]),
      .cfg_i     (cfg[i]),
      .busy_i    (busy[i]),
      .load_i    (load_pin[i]),
      .accept_i  (accept[i]),
      .eoi_hit_i (eoi_hit[i]),
      .req_o     (req[i]),
      .racc_o    (racc[i]),
      .status_o  (status[i])
    );
  end

  irq_rr_arbiter #(.N_PINS(N_PINS), .IDX_W(IDX_W)) i_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req),
    .advance_i (load),
    .gnt_any_o (gnt_any),
    .gnt_idx_o (gnt_idx)
  );

  assign load = gnt_any && (!out_valid_q || msg_ready);
  assign gcfg = cfg[gnt_idx];

  always_comb begin
    out_valid_d = out_valid_q;
    out_pin_d   = out_pin_q;
    out_vec_d   = out_vec_q;
    out_dlv_d   = out_dlv_q;
    out_log_d   = out_log_q;
    out_dest_d  = out_dest_q;
    if (load) begin
      out_valid_d = 1'b1;
      out_pin_d   = gnt_idx;
      out_vec_d   = gcfg.vec;
      out_dlv_d   = gcfg.dlv;
      out_log_d   = gcfg.logical;
      out_dest_d  = gcfg.logical ? gcfg.dest : {4'b0000, gcfg.dest[3:0]};
    end else if (msg_ready) begin
      out_valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid_q <= 1'b0;
    else        out_valid_q <= out_valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_pin_q  <= '0;
      out_vec_q  <= '0;
      out_dlv_q  <= '0;
      out_log_q  <= 1'b0;
      out_dest_q <= '0;
    end else if (load) begin
      out_pin_q  <= out_pin_d;
      out_vec_q  <= out_vec_d;
      out_dlv_q  <= out_dlv_d;
      out_log_q  <= out_log_d;
      out_dest_q <= out_dest_d;
    end
  end

  assign msg_valid   = out_valid_q;
  assign msg_vector  = out_vec_q;
  assign msg_dlv     = out_dlv_q;
  assign msg_logical = out_log_q;
  assign msg_dest    = out_dest_q;

  always_comb begin
    cfg_rdata = '0;
    if (int'(cfg_addr) < N_PINS)
      cfg_rdata = pack_entry(cfg[cfg_addr], status[cfg_addr], racc[cfg_addr]);
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> msg_valid && $stable(msg_vector) &&
                                  $stable(msg_dest) && $stable(msg_dlv)); // R9

  AST_PHYS_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_logical) |-> (msg_dest[7:4] == 4'b0000)); // R8

  AST_ONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(busy)); // R10

  AST_SEND_NOT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !(cfg[gnt_idx].trig && racc[gnt_idx])); // R6

endmodule

// File: tb/test_irq_router.sv
module test_irq_router;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] irq_pin;
  logic        cfg_we;
  logic [4:0]  cfg_addr;
  logic [63:0] cfg_wdata;
  logic [63:0] cfg_rdata;
  logic        eoi_valid;
  logic [7:0]  eoi_vector;
  logic        msg_valid, msg_ready, msg_logical;
  logic [7:0]  msg_vector, msg_dest;
  logic [2:0]  msg_dlv;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  typedef struct { logic [19:0] m; string tag; } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  irq_router i_irq_router (
    .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
    .msg_dlv(msg_dlv), .msg_logical(msg_logical), .msg_dest(msg_dest)
  );

  function automatic logic [63:0] mk(input logic [7:0] vec, input logic [2:0] dlv,
                                     input logic lg, input logic pol, input logic trig,
                                     input logic msk, input logic [7:0] dest);
    return {dest, 39'b0, msk, trig, 1'b0, pol, 1'b0, lg, dlv, vec};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(input string tag, input logic [7:0] vec, input logic [2:0] dlv,
                      input logic lg, input logic [7:0] dest);
    exp_t e;
    e.m   = {(lg ? dest : {4'b0, dest[3:0]}), lg, dlv, vec};
    e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    #2;
    if (rst_n && msg_valid && msg_ready) begin
      exp_t e;
      logic [19:0] got;
      got = {msg_dest, msg_logical, msg_dlv, msg_vector};
      tests++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R3/R5/R6: unexpected message actual %h expected none", got);
      end else begin
        e = sb.pop_front();
        if (got !== e.m) begin
          fails++;
          $display("FAIL %s: message actual %h expected %h", e.tag, got, e.m);
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] idx, input logic [63:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [4:0] idx, input logic [63:0] exp);
    @(negedge clk);
    cfg_addr = idx;
    #1;
    chk(tag, cfg_rdata, exp);
  endtask

  task automatic rd_bit(input string tag, input logic [4:0] idx, input int b, input logic exp);
    @(negedge clk);
    cfg_addr = idx;
    #1;
    chk(tag, {63'b0, cfg_rdata[b]}, {63'b0, exp});
  endtask

  task automatic eoi(input logic [7:0] v);
    @(negedge clk);
    eoi_valid = 1'b1; eoi_vector = v;
    @(negedge clk);
    eoi_valid = 1'b0;
  endtask

  task automatic pulse(input logic [23:0] m);
    @(negedge clk);
    irq_pin = irq_pin ^ m;
    @(negedge clk);
    irq_pin = irq_pin ^ m;
  endtask

  task automatic drain(input string tag);
    for (int k = 0; k < 300; k++) begin
      if (sb.size() == 0) break;
      @(negedge clk);
    end
    cyc(20);
    chk(tag, 64'(sb.size()), 64'd0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] held_vec;
    rst_n = 1'b0; irq_pin = '0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    eoi_valid = 1'b0; eoi_vector = '0; msg_ready = 1'b1;
    cyc(3);
    rst_n = 1'b1;
    irq_pin[2] = 1'b1;

    // R1 reset state
    chk("R1 msg_valid", {63'b0, msg_valid}, 64'd0);
    rd("R1 entry0", 5'd0, 64'h0000_0000_0001_0000);
    rd("R1 entry23", 5'd23, 64'h0000_0000_0001_0000);

    // R2 field write / readback, reserved zero, read-only bits
    wr(5'd5, 64'hFFFF_FFFF_FFFF_FFFF);
    rd("R2 all-ones write", 5'd5, 64'hFF00_0000_0001_AFFF);
    wr(5'd5, 64'h0000_0000_0001_0000);
    rd("R2 restore", 5'd5, 64'h0000_0000_0001_0000);

    // R3 + R8 physical: edge pin 1, dest field A5 -> 05
    wr(5'd1, mk(8'h31, 3'b001, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5));
    push("R3/R8 edge physical", 8'h31, 3'b001, 1'b0, 8'hA5);
    @(negedge clk); irq_pin[1] = 1'b1;
    drain("R3 single message");
    cyc(10);
    chk("R3 no repeat while held", 64'(sb.size()) + {63'b0, msg_valid}, 64'd0);
    irq_pin[1] = 1'b0;

    // R4 + R8 logical: active-low edge pin 2
    wr(5'd2, mk(8'h42, 3'b010, 1'b1, 1'b1, 1'b0, 1'b0, 8'hC3));
    cyc(5);
    chk("R4 no msg at config", {63'b0, msg_valid}, 64'd0);
    push("R4/R8 falling edge logical", 8'h42, 3'b010, 1'b1, 8'hC3);
    @(negedge clk); irq_pin[2] = 1'b0;
    drain("R4 falling triggers");
    @(negedge clk); irq_pin[2] = 1'b1;
    cyc(10);
    chk("R4 rising ignored", {63'b0, msg_valid}, 64'd0);

    // R5 masked edge discarded
    wr(5'd3, mk(8'h53, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 8'h01));
    pulse(24'h000008);
    cyc(5);
    wr(5'd3, mk(8'h53, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01));
    cyc(20);
    chk("R5 masked edge dropped", {63'b0, msg_valid}, 64'd0);

    // R6/R7/R9/R12 level pin 4
    wr(5'd4, mk(8'h64, 3'b000, 1'b0, 1'b0, 1'b1, 1'b0, 8'h02));
    @(negedge clk); msg_ready = 1'b0;
    push("R6 level message", 8'h64, 3'b000, 1'b0, 8'h02);
    irq_pin[4] = 1'b1;
    cyc(3);
    chk("R9 valid raised", {63'b0, msg_valid}, 64'd1);
    held_vec = msg_vector;
    rd_bit("R12 status while presented", 5'd4, 12, 1'b1);
    cyc(4);
    chk("R9 valid held", {63'b0, msg_valid}, 64'd1);
    chk("R9 vector stable", {56'b0, msg_vector}, {56'b0, held_vec});
    msg_ready = 1'b1;
    drain("R6 first level message");
    rd_bit("R6 remote bit set", 5'd4, 14, 1'b1);
    rd_bit("R12 status cleared", 5'd4, 12, 1'b0);
    cyc(20);
    chk("R6 blocked while remote", {63'b0, msg_valid}, 64'd0);
    eoi(8'h99);
    cyc(5);
    rd_bit("R7 wrong vector no effect", 5'd4, 14, 1'b1);
    chk("R7 wrong vector no msg", {63'b0, msg_valid}, 64'd0);
    push("R7 resend after eoi", 8'h64, 3'b000, 1'b0, 8'h02);
    eoi(8'h64);
    drain("R7 resend");
    rd_bit("R7 remote set again", 5'd4, 14, 1'b1);
    @(negedge clk); irq_pin[4] = 1'b0;
    eoi(8'h64);
    cyc(5);
    rd_bit("R7 remote cleared", 5'd4, 14, 1'b0);
    chk("R7 inactive no msg", {63'b0, msg_valid}, 64'd0);

    // R10 rotating order (pointer now after pin 4)
    wr(5'd8,  mk(8'h88, 3'b001, 1'b0, 1'b0, 1'b0, 1'b0, 8'h08));
    wr(5'd12, mk(8'h8C, 3'b010, 1'b0, 1'b0, 1'b0, 1'b0, 8'h0C));
    wr(5'd20, mk(8'hA0, 3'b100, 1'b1, 1'b0, 1'b0, 1'b0, 8'h3C));
    wr(5'd22, mk(8'hA2, 3'b111, 1'b0, 1'b0, 1'b0, 1'b0, 8'h07));
    @(negedge clk); msg_ready = 1'b0;
    push("R10 round1 pin8", 8'h88, 3'b001, 1'b0, 8'h08);
    push("R10 round1 pin12", 8'h8C, 3'b010, 1'b0, 8'h0C);
    push("R10 round1 pin20", 8'hA0, 3'b100, 1'b1, 8'h3C);
    pulse(24'h101100);
    cyc(5);
    msg_ready = 1'b1;
    drain("R10 round1");
    @(negedge clk); msg_ready = 1'b0;
    push("R10 wrap pin22 first", 8'hA2, 3'b111, 1'b0, 8'h07);
    push("R10 wrap pin8 second", 8'h88, 3'b001, 1'b0, 8'h08);
    pulse(24'h400100);
    cyc(5);
    msg_ready = 1'b1;
    drain("R10 wrap order");

    // R11 mask after presentation
    wr(5'd9, mk(8'h99, 3'b011, 1'b0, 1'b0, 1'b0, 1'b0, 8'h09));
    @(negedge clk); msg_ready = 1'b0;
    push("R11 masked late still sent", 8'h99, 3'b011, 1'b0, 8'h09);
    pulse(24'h000200);
    cyc(3);
    wr(5'd9, mk(8'h99, 3'b011, 1'b0, 1'b0, 1'b0, 1'b1, 8'h09));
    cyc(2);
    msg_ready = 1'b1;
    drain("R11 message kept");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule